// File: doc/BRIEF.md
# Interrupt Requester-ID Validation Checker

This block decides whether a remappable interrupt request may use the remapping table entry already fetched for it. The requester ID that came with the interrupt write is checked against three fields of that entry: a 16-bit source-ID field, a 2-bit validation-type field and a 2-bit qualifier. If the check fails, the interrupt is to be dropped. The block then reports a fixed, nonzero source-ID fault code in place of a pass.

Requests enter on a valid/ready interface. A request is taken on any clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low only while reset is applied and for the first edge after it. It never depends on the result side, because results cannot stall: every accepted request yields exactly one `res_valid` pulse one cycle later. That pulse carries the pass flag, the fault code and the echoed entry index. The upstream stage needs no buffering beyond holding its request until it sees `req_ready`. A separate input marks a write that carried no requester ID, and such a request always passes.

Top module: `irq_sid_check`

## Requirements
- R1: `req_ready` is low in the cycle after any clock edge with `rst` high, and high in the cycle after any clock edge with `rst` low.
- R2: `res_valid` is high for exactly the one cycle following an edge on which `req_valid && req_ready`; otherwise it is low.
- R3: `res_entry_idx` equals the `req_entry_idx` of the accepted request while `res_valid` is high.
- R4: Validation type 0 (`ent_svt` = 2'b00) always passes.
- R5: Validation type 1 passes only when `(ent_sid & M) == (req_rid & M)`. M depends on `ent_sq`: 0 gives 16'hFFFF, 1 gives 16'hFFFB (bit 2 ignored), 2 gives 16'hFFF9 (bits 2:1 ignored) and 3 gives 16'hFFF8 (bits 2:0 ignored).
- R6: Validation type 2 passes only when the requester bus `req_rid[15:8]` lies between `ent_sid[7:0]` (minimum) and `ent_sid[15:8]` (maximum), both bounds inclusive.
- R7: Validation type 3 is reserved and always fails, even when the IDs match.
- R8: When `req_rid_unknown` is high, the result is pass whatever the entry fields hold.
- R9: `res_fault_code` is 0 on a pass and equals parameter `SID_FAULT_CODE` (default 8'h0C) on a failure.
- R10: A clock edge with `rst` high clears `res_valid`, `res_pass`, `res_fault_code` and `res_entry_idx` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_rid | input | 16 | Requester ID of the interrupt write |
| req_rid_unknown | input | 1 | Write carried no requester ID |
| req_entry_idx | input | 16 | Index of the table entry being used |
| ent_sid | input | 16 | Entry source-ID field (bus max/min for type 2) |
| ent_svt | input | 2 | Entry validation type |
| ent_sq | input | 2 | Entry qualifier selecting the compare mask |
| res_valid | output | 1 | One-cycle result strobe |
| res_pass | output | 1 | 1 when the interrupt may proceed |
| res_fault_code | output | 8 | 0 on pass, source-ID fault code on failure |
| res_entry_idx | output | 16 | Entry index of the checked request |

## Verification
Three cases are hard to reach from the ports. The first is a result that depends on a single ignored ID bit, or on a requester bus sitting exactly on a range bound. The vector table places the requester one step inside and one step outside each mask and each bound. The second is the precedence of the unknown-requester flag over failing entries, including the reserved type. This is reached by pairing that flag with entries that fail on their own. The third is a reset that arrives in the same cycle a result is on the outputs, which is forced by asserting reset directly after an accepted failing request.

// File: rtl/irq_sid_pkg.sv
package irq_sid_pkg;

  typedef enum logic [1:0] {
    SVT_NONE     = 2'd0,
    SVT_EXACT    = 2'd1,
    SVT_BUSRANGE = 2'd2,
    SVT_RESERVED = 2'd3
  } svt_e;

endpackage

// File: rtl/irq_sid_mask_cmp.sv
module irq_sid_mask_cmp #(
  parameter int RID_W = 16
) (
  input  logic [RID_W-1:0] rid,
  input  logic [RID_W-1:0] sid,
  input  logic [1:0]       qual,
  output logic             match
);
  logic [3:0]       low_run;
  logic [RID_W-1:0] ignore;
  logic [RID_W-1:0] mask;

  // qual q ignores a run of q bits ending at bit 2
  always_comb begin
    low_run = (4'b0001 << qual) - 4'b0001;
    ignore  = RID_W'(low_run) << (2'd3 - qual);
    mask    = ~ignore;
    match   = ((rid ^ sid) & mask) == '0;
  end
endmodule

// File: rtl/irq_sid_bus_range.sv
module irq_sid_bus_range #(
  parameter int RID_W = 16
) (
  input  logic [RID_W-1:0] rid,
  input  logic [RID_W-1:0] bounds,
  output logic             in_range
);
  localparam int BUS_W = RID_W / 2;

  logic [BUS_W-1:0] bus, bus_max, bus_min;

  always_comb begin
    bus      = rid[RID_W-1 -: BUS_W];
    bus_max  = bounds[RID_W-1 -: BUS_W];
    bus_min  = bounds[BUS_W-1:0];
    in_range = (bus <= bus_max) && (bus >= bus_min);
  end
endmodule

// File: rtl/irq_sid_result_reg.sv
module irq_sid_result_reg #(
  parameter int          IDX_W      = 16,
  parameter int          FC_W       = 8,
  parameter logic [FC_W-1:0] FAULT_CODE = 8'h0C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             pass_in,
  input  logic [IDX_W-1:0] idx_in,
  output logic             res_valid,
  output logic             res_pass,
  output logic [FC_W-1:0]  res_code,
  output logic [IDX_W-1:0] res_idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_pass  <= 1'b0;
      res_code  <= '0;
      res_idx   <= '0;
    end else begin
      res_valid <= load;
      if (load) begin
        res_pass <= pass_in;
        res_code <= pass_in ? '0 : FAULT_CODE;
        res_idx  <= idx_in;
      end
    end
  end

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (!res_valid && !res_pass && res_code == '0 && res_idx == '0));

  a_r9_code_tracks_pass: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_pass ? (res_code == '0) : (res_code == FAULT_CODE)));
endmodule

// File: rtl/irq_sid_check.sv
module irq_sid_check
  import irq_sid_pkg::*;
#(
  parameter int              RID_W          = 16,
  parameter int              IDX_W          = 16,
  parameter int              FC_W           = 8,
  parameter logic [FC_W-1:0] SID_FAULT_CODE = 8'h0C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [RID_W-1:0] req_rid,
  input  logic             req_rid_unknown,
  input  logic [IDX_W-1:0] req_entry_idx,
  input  logic [RID_W-1:0] ent_sid,
  input  logic [1:0]       ent_svt,
  input  logic [1:0]       ent_sq,
  output logic             res_valid,
  output logic             res_pass,
  output logic [FC_W-1:0]  res_fault_code,
  output logic [IDX_W-1:0] res_entry_idx
);
  logic accept;
  logic exact_ok, range_ok, pass_now;
  svt_e vtype;

  always_ff @(posedge clk) begin
    req_ready <= !rst;
  end

  assign accept = req_valid && req_ready;
  assign vtype  = svt_e'(ent_svt);

  irq_sid_mask_cmp #(.RID_W(RID_W)) u_mask (
    .rid(req_rid), .sid(ent_sid), .qual(ent_sq), .match(exact_ok)
  );

  irq_sid_bus_range #(.RID_W(RID_W)) u_range (
    .rid(req_rid), .bounds(ent_sid), .in_range(range_ok)
  );

  always_comb begin
    if (req_rid_unknown) begin
      pass_now = 1'b1;
    end else begin
      unique case (vtype)
        SVT_NONE:     pass_now = 1'b1;
        SVT_EXACT:    pass_now = exact_ok;
        SVT_BUSRANGE: pass_now = range_ok;
        default:      pass_now = 1'b0;
      endcase
    end
  end

  irq_sid_result_reg #(
    .IDX_W(IDX_W), .FC_W(FC_W), .FAULT_CODE(SID_FAULT_CODE)
  ) u_res (
    .clk(clk), .rst(rst), .load(accept), .pass_in(pass_now),
    .idx_in(req_entry_idx), .res_valid(res_valid), .res_pass(res_pass),
    .res_code(res_fault_code), .res_idx(res_entry_idx)
  );

  a_r1_ready_low_in_reset: assert property (@(posedge clk)
    rst |=> !req_ready);

  a_r2_strobe_after_accept: assert property (@(posedge clk) disable iff (rst)
    accept |=> res_valid);

  a_r2_no_strobe_idle: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !res_valid);

  a_r3_index_echo: assert property (@(posedge clk) disable iff (rst)
    accept |=> (res_entry_idx == $past(req_entry_idx)));

  a_r8_unknown_passes: assert property (@(posedge clk) disable iff (rst)
    (accept && req_rid_unknown) |=> res_pass);

  a_r7_reserved_fails: assert property (@(posedge clk) disable iff (rst)
    (accept && !req_rid_unknown && ent_svt == 2'd3) |=> !res_pass);

  a_r4_none_passes: assert property (@(posedge clk) disable iff (rst)
    (accept && ent_svt == 2'd0) |=> res_pass);
endmodule

// File: tb/tb_irq_sid_check.sv
module tb_irq_sid_check;
  localparam logic [7:0] FC = 8'h0C;
  // {rid[16], unknown, sid[16], svt[2], sq[2], exp_pass}
  localparam int NV = 17;
  localparam logic [37:0] VEC [NV] = '{
    {16'h1234, 1'b0, 16'h9999, 2'd0, 2'd0, 1'b1}, // R4
    {16'h0310, 1'b0, 16'h0310, 2'd1, 2'd0, 1'b1}, // R5 exact
    {16'h0318, 1'b0, 16'h0310, 2'd1, 2'd0, 1'b0}, // R5 exact miss
    {16'h0314, 1'b0, 16'h0310, 2'd1, 2'd1, 1'b1}, // R5 bit2 ignored
    {16'h0318, 1'b0, 16'h0310, 2'd1, 2'd1, 1'b0}, // R5 bit3 kept
    {16'h0316, 1'b0, 16'h0310, 2'd1, 2'd2, 1'b1}, // R5 bits2:1 ignored
    {16'h0311, 1'b0, 16'h0310, 2'd1, 2'd2, 1'b0}, // R5 bit0 kept
    {16'h0317, 1'b0, 16'h0310, 2'd1, 2'd3, 1'b1}, // R5 bits2:0 ignored
    {16'h0410, 1'b0, 16'h0310, 2'd1, 2'd3, 1'b0}, // R5 bus differs
    {16'h0500, 1'b0, 16'h0502, 2'd2, 2'd0, 1'b1}, // R6 at max
    {16'h02FF, 1'b0, 16'h0502, 2'd2, 2'd0, 1'b1}, // R6 at min
    {16'h0600, 1'b0, 16'h0502, 2'd2, 2'd0, 1'b0}, // R6 above
    {16'h0100, 1'b0, 16'h0502, 2'd2, 2'd0, 1'b0}, // R6 below
    {16'h0310, 1'b0, 16'h0310, 2'd3, 2'd0, 1'b0}, // R7
    {16'h0310, 1'b1, 16'h0310, 2'd3, 2'd0, 1'b1}, // R8 reserved
    {16'h0318, 1'b1, 16'h0310, 2'd1, 2'd0, 1'b1}, // R8 mismatch
    {16'h0100, 1'b1, 16'h0502, 2'd2, 2'd0, 1'b1}  // R8 out of range
  };

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_rid_unknown = 1'b0;
  logic [15:0] req_rid = '0, req_entry_idx = '0, ent_sid = '0;
  logic [1:0] ent_svt = '0, ent_sq = '0;
  logic req_ready, res_valid, res_pass;
  logic [7:0] res_fault_code;
  logic [15:0] res_entry_idx;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  irq_sid_check dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_rid(req_rid), .req_rid_unknown(req_rid_unknown),
    .req_entry_idx(req_entry_idx), .ent_sid(ent_sid), .ent_svt(ent_svt),
    .ent_sq(ent_sq), .res_valid(res_valid), .res_pass(res_pass),
    .res_fault_code(res_fault_code), .res_entry_idx(res_entry_idx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [37:0] v, input logic [15:0] idx);
    req_valid       = 1'b1;
    req_rid         = v[37:22];
    req_rid_unknown = v[21];
    ent_sid         = v[20:5];
    ent_svt         = v[4:3];
    ent_sq          = v[2:1];
    req_entry_idx   = idx;
  endtask

  task automatic check_result(input logic exp_pass, input logic [15:0] idx, input string req);
    chk({req, " valid R2"}, 32'(res_valid), 32'd1);
    chk(req, 32'(res_pass), 32'(exp_pass));
    chk({req, " code R9"}, 32'(res_fault_code), exp_pass ? 32'd0 : 32'(FC));
    chk({req, " index R3"}, 32'(res_entry_idx), 32'(idx));
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 ready in reset", 32'(req_ready), 32'd0);
    chk("R10 valid in reset", 32'(res_valid), 32'd0);
    chk("R10 pass in reset", 32'(res_pass), 32'd0);
    chk("R10 code in reset", 32'(res_fault_code), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", 32'(req_ready), 32'd1);

    // table walk: one request every other cycle, result one cycle later
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i], 16'h0100 + 16'(i));
      @(negedge clk);
      req_valid = 1'b0;
      check_result(VEC[i][0], 16'h0100 + 16'(i), $sformatf("R4-8 vec%0d", i));
      @(negedge clk);
      chk("R2 idle no strobe", 32'(res_valid), 32'd0);
    end

    // back-to-back: fail then pass on consecutive edges
    drive(VEC[2], 16'hBEEF);
    @(negedge clk);
    check_result(1'b0, 16'hBEEF, "R5 b2b first");
    drive(VEC[0], 16'hCAFE);
    @(negedge clk);
    req_valid = 1'b0;
    check_result(1'b1, 16'hCAFE, "R4 b2b second");

    // reset right after a failing result is presented
    drive(VEC[13], 16'h7777);
    @(negedge clk);
    req_valid = 1'b0;
    check_result(1'b0, 16'h7777, "R7 before reset");
    rst = 1'b1;
    @(negedge clk);
    chk("R10 valid cleared", 32'(res_valid), 32'd0);
    chk("R10 code cleared", 32'(res_fault_code), 32'd0);
    chk("R10 index cleared", 32'(res_entry_idx), 32'd0);
    chk("R1 ready dropped", 32'(req_ready), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready restored", 32'(req_ready), 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule